// File: doc/BRIEF.md
# Machine Clock Source Selection Controller

This block chooses which of three sources drives the machine clock: the main oscillator, a multiplied PLL clock, or a slow sub-clock. Software programs it through one 8-bit control register. The register holds two request bits, a multiplier field, a stabilization-wait field, and two read-only bits that show the source currently in use. When a request names a source other than the active one, the controller first counts a stabilization wait. It then passes through a two-stage synchronization and only after that commits the new source.

The rules are not symmetric between sources. A cleared sub-clock request always wins. Leaving the sub-clock needs a main-oscillator wait. Every entry into PLL mode needs a relock wait. A direct jump from the sub-clock to the PLL must use one of the two longer waits. Any register write or watchdog event made while a switch is pending abandons that switch. Evaluation then starts again from the source that is actually active, so the status bits never show an intermediate state. The analog sources are outside this block; only the selection decision and its timing are built here.

Top module: `clk_source_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x03, `clk_src` is 0 (main), `pll_mult` is 0 and `ws_err` is 0.
- R2: Register bit layout: bit 0 is the PLL request (0 = use PLL), bit 1 is the sub-clock request (0 = use sub-clock), bits 3:2 are the multiplier, bits 5:4 are the wait select, bit 6 reads 1 while the PLL is in use, and bit 7 reads 1 while the sub-clock is in use. Bits 5:0 take the written value at the write edge. Written values of bits 7:6 are ignored.
- R3: Wait select values 0, 1, 2 and 3 give waits of 2^WS_EXP0, 2^WS_EXP1, 2^WS_EXP2 and 2^WS_EXP3 cycles (2^10, 2^13, 2^15, 2^17 by default). A switch from main to PLL commits exactly wait+3 cycles after the write edge. At that point `pll_mult` takes the multiplier field.
- R4: Setting the PLL request to 1 while the PLL is active returns the clock to main exactly 3 cycles after the write edge, with no wait.
- R5: A `wdog_rst` pulse sets the PLL request bit to 1 at its edge. This overrides a write of 0 to that bit in the same cycle, while the other bits of that write are still taken. The pulse then acts like a write.
- R6: A sub-clock request of 0 selects the sub-clock whatever the PLL request holds. The switch commits 2^SUB_EXP+3 cycles after the write edge.
- R7: Setting the sub-clock request to 1 while on the sub-clock moves to main, or to PLL if the PLL request is 0. The switch commits after the wait chosen by the wait select field, plus 3 cycles.
- R8: On a sub-to-PLL switch with wait select 0 or 1, the wait used is that of value 2. `ws_err` is then high for exactly the one cycle that follows the write edge. It is low otherwise.
- R9: The source outputs change only when a switch commits. A write or watchdog pulse during a pending switch restarts the timing, so the commit comes wait+3 cycles after the last write.
- R10: A write whose requested source equals the active source causes no switch. In particular, changing the multiplier while on the PLL leaves `pll_mult` unchanged.
- R11: `clk_src` encodes main = 0, PLL = 1, sub = 2, and never 3. `pll_mult` is 0 unless the PLL is active. Status bits 6 and 7 are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| wdog_rst | input | 1 | Watchdog event, forces the PLL request off |
| rd_data | output | 8 | Register readback including status bits |
| clk_src | output | 2 | Active source: 0 main, 1 PLL, 2 sub |
| pll_mult | output | 2 | Multiplier in use while the PLL is active |
| ws_err | output | 1 | One-cycle flag for a too-short sub-to-PLL wait |

## Verification
A register write and a watchdog event can land on the same edge, and both touch the PLL request bit. The bench provokes this by pulsing `wdog_rst` together with a write that clears the PLL request and also changes the multiplier and wait fields. The register is judged correct when the readback shows the PLL request at 1 and the other written fields taken, and no switch follows. The bench also drives watchdog pulses at random alongside random writes. Each one is checked against a bench model of the register and of the expected commit cycle.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_PLL  = 2'd1,
        SRC_SUB  = 2'd2
    } src_e;

    typedef struct packed {
        logic [1:0] ws;
        logic [1:0] mult;
        logic       sub_req_n;
        logic       pll_req_n;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic src_e pick_target(ctrl_t c);
        if (!c.sub_req_n)      return SRC_SUB;
        else if (!c.pll_req_n) return SRC_PLL;
        else                   return SRC_MAIN;
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/clk_ctrl_reg.sv
module clk_ctrl_reg
    import clk_src_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wdog_rst,
    input  src_e       active,
    output ctrl_t      ctrl,
    output logic       touch,
    output logic [7:0] rd_data
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{ws: 2'b00, mult: 2'b00, sub_req_n: 1'b1, pll_req_n: 1'b1};
        end else begin
            if (wr_en) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wdog_rst) ctrl_q.pll_req_n <= 1'b1;
        end
    end

    assign ctrl    = ctrl_q;
    assign touch   = wr_en | wdog_rst;
    assign rd_data = {active == SRC_SUB, active == SRC_PLL, ctrl_q};

    assert_wdog_forces_R5: assert property (@(posedge clk) disable iff (rst)
        $past(wdog_rst) |-> ctrl_q.pll_req_n);

endmodule

// File: rtl/clk_wait_timer.sv
module clk_wait_timer #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                   cnt_q <= '0;
        else if (load)             cnt_q <= load_val;
        else if (run && cnt_q > 1) cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q <= 1);

endmodule

// File: rtl/clk_switch_fsm.sv
module clk_switch_fsm
    import clk_src_pkg::*;
#(
    parameter int WS_EXP0 = 10,
    parameter int WS_EXP1 = 13,
    parameter int WS_EXP2 = 15,
    parameter int WS_EXP3 = 17,
    parameter int SUB_EXP = 14,
    parameter int CW      = 18
) (
    input  logic       clk,
    input  logic       rst,
    input  ctrl_t      ctrl,
    input  logic       touch,
    output src_e       active,
    output logic [1:0] pll_mult,
    output logic       ws_err
);
    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SYNC1, ST_SYNC2} st_e;

    st_e           st_q;
    src_e          act_q, tgt_q, tgt;
    logic [1:0]    mult_q, run_mult_q;
    logic          err_q, need_err, timer_last, eval;
    logic [CW-1:0] wait_len;
    logic [1:0]    ws_eff;

    function automatic logic [CW-1:0] ws_cycles(logic [1:0] ws);
        case (ws)
            2'd0:    return CW'(1) << WS_EXP0;
            2'd1:    return CW'(1) << WS_EXP1;
            2'd2:    return CW'(1) << WS_EXP2;
            default: return CW'(1) << WS_EXP3;
        endcase
    endfunction

    always_comb begin
        tgt      = pick_target(ctrl);
        need_err = (act_q == SRC_SUB) && (tgt == SRC_PLL) && !ctrl.ws[1];
        ws_eff   = need_err ? 2'd2 : ctrl.ws;
        if (tgt == SRC_SUB)        wait_len = CW'(1) << SUB_EXP;
        else if (tgt == SRC_MAIN && act_q == SRC_PLL) wait_len = '0;
        else                       wait_len = ws_cycles(ws_eff);
        eval = (st_q == ST_IDLE) && !touch && (tgt != act_q);
    end

    clk_wait_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (eval),
        .load_val (wait_len),
        .run      (st_q == ST_WAIT),
        .last     (timer_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            act_q      <= SRC_MAIN;
            tgt_q      <= SRC_MAIN;
            mult_q     <= '0;
            run_mult_q <= '0;
            err_q      <= 1'b0;
        end else begin
            err_q <= eval && need_err;
            if (touch) begin
                st_q <= ST_IDLE;
            end else begin
                case (st_q)
                    ST_IDLE: if (eval) begin
                        tgt_q  <= tgt;
                        mult_q <= ctrl.mult;
                        st_q   <= (wait_len == '0) ? ST_SYNC1 : ST_WAIT;
                    end
                    ST_WAIT:  if (timer_last) st_q <= ST_SYNC1;
                    ST_SYNC1: st_q <= ST_SYNC2;
                    ST_SYNC2: begin
                        act_q      <= tgt_q;
                        run_mult_q <= (tgt_q == SRC_PLL) ? mult_q : 2'd0;
                        st_q       <= ST_IDLE;
                    end
                    default:  st_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign active   = act_q;
    assign pll_mult = run_mult_q;
    assign ws_err   = err_q;

    assert_commit_after_sync_R9: assert property (@(posedge clk) disable iff (rst)
        (act_q != $past(act_q)) |-> ($past(st_q) == ST_SYNC2));
    assert_err_only_on_sub_R8: assert property (@(posedge clk) disable iff (rst)
        err_q |-> (act_q == SRC_SUB));
    assert_mult_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (act_q == SRC_PLL && $past(act_q) == SRC_PLL) |-> $stable(run_mult_q));

endmodule

// File: rtl/clk_source_ctrl.sv
module clk_source_ctrl
    import clk_src_pkg::*;
#(
    parameter int WS_EXP0 = 10,
    parameter int WS_EXP1 = 13,
    parameter int WS_EXP2 = 15,
    parameter int WS_EXP3 = 17,
    parameter int SUB_EXP = 14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wdog_rst,
    output logic [7:0] rd_data,
    output logic [1:0] clk_src,
    output logic [1:0] pll_mult,
    output logic       ws_err
);
    localparam int MAX_EXP = max_of(max_of(max_of(WS_EXP0, WS_EXP1),
                                           max_of(WS_EXP2, WS_EXP3)), SUB_EXP);
    localparam int CW = MAX_EXP + 1;

    ctrl_t ctrl;
    src_e  active;
    logic  touch;

    clk_ctrl_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wdog_rst (wdog_rst),
        .active   (active),
        .ctrl     (ctrl),
        .touch    (touch),
        .rd_data  (rd_data)
    );

    clk_switch_fsm #(
        .WS_EXP0 (WS_EXP0), .WS_EXP1 (WS_EXP1),
        .WS_EXP2 (WS_EXP2), .WS_EXP3 (WS_EXP3),
        .SUB_EXP (SUB_EXP), .CW      (CW)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .touch    (touch),
        .active   (active),
        .pll_mult (pll_mult),
        .ws_err   (ws_err)
    );

    assign clk_src = active;

    assert_status_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(rd_data[6] && rd_data[7]) && (clk_src != 2'd3));
    assert_mult_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (clk_src != 2'd1) |-> (pll_mult == 2'd0));

endmodule

// File: tb/clk_source_ctrl_tb.sv
module clk_source_ctrl_tb;
    localparam int E0 = 2, E1 = 3, E2 = 4, E3 = 5, SE = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wdog_rst = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] clk_src, pll_mult;
    logic       ws_err;

    int tests = 0, fails = 0;
    logic [5:0] m_reg;
    int m_act, m_mult;

    always #10 clk = ~clk;

    clk_source_ctrl #(.WS_EXP0(E0), .WS_EXP1(E1), .WS_EXP2(E2),
                      .WS_EXP3(E3), .SUB_EXP(SE)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .wdog_rst(wdog_rst), .rd_data(rd_data), .clk_src(clk_src),
        .pll_mult(pll_mult), .ws_err(ws_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int m_target(logic [5:0] r);
        if (!r[1]) return 2;
        if (!r[0]) return 1;
        return 0;
    endfunction

    function automatic int ws_len(int ws);
        case (ws)
            0: return 1 << E0;
            1: return 1 << E1;
            2: return 1 << E2;
            default: return 1 << E3;
        endcase
    endfunction

    function automatic int m_wait(int act, int tgt, int ws);
        if (tgt == 2) return 1 << SE;
        if (tgt == 0 && act == 1) return 0;
        if (act == 2 && tgt == 1 && ws < 2) return ws_len(2);
        return ws_len(ws);
    endfunction

    task automatic chk_status(input string tag);
        chk({tag, " src"}, clk_src, m_act);
        chk({tag, " mult"}, pll_mult, m_mult);
        chk({tag, " pll bit"}, rd_data[6], m_act == 1);
        chk({tag, " sub bit"}, rd_data[7], m_act == 2);
    endtask

    task automatic wr(input logic [7:0] d, input logic we, input logic wd);
        @(negedge clk);
        wr_en = we; wr_data = d; wdog_rst = wd;
        @(negedge clk);
        wr_en = 1'b0; wdog_rst = 1'b0;
        if (we) m_reg = d[5:0];
        if (wd) m_reg[0] = 1'b1;
        chk("R2 R5 readback", rd_data[5:0], m_reg);
    endtask

    task automatic settle(input string tag);
        int tgt, c, e;
        tgt = m_target(m_reg);
        if (tgt == m_act) begin
            repeat (40) @(negedge clk);
            chk({tag, " R10 no switch ws_err"}, ws_err, 0);
            chk_status({tag, " R10 no switch"});
        end else begin
            c = m_wait(m_act, tgt, int'(m_reg[5:4]));
            e = (m_act == 2 && tgt == 1 && m_reg[5:4] < 2) ? 1 : 0;
            @(negedge clk);
            chk({tag, " R8 ws_err"}, ws_err, e);
            repeat (c + 1) @(negedge clk);
            chk({tag, " R9 before commit"}, clk_src, m_act);
            chk({tag, " R8 ws_err low"}, ws_err, 0);
            @(negedge clk);
            m_act  = tgt;
            m_mult = (tgt == 1) ? int'(m_reg[3:2]) : 0;
            chk_status({tag, " R3 R4 R6 R7 commit"});
        end
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        m_reg = 6'h03; m_act = 0; m_mult = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rd_data", rd_data, 8'h03);
        chk("R1 src", clk_src, 0);
        chk("R1 mult", pll_mult, 0);
        chk("R1 ws_err", ws_err, 0);

        // R2: status bits written 1 are ignored
        wr(8'hC3, 1'b1, 1'b0);
        chk("R2 ro bits", rd_data[7:6], 0);
        settle("R2");
        // R3: main to PLL with wait select 1, multiplier 3
        wr(8'h1E, 1'b1, 1'b0); settle("R3 main->pll");
        // R10: multiplier change on PLL is ignored
        wr(8'h16, 1'b1, 1'b0); settle("R10 mult change");
        // R4: PLL back to main, no wait
        wr(8'h03, 1'b1, 1'b0); settle("R4 pll->main");
        // R5: watchdog overrides PLL request in same cycle
        wr(8'h3A, 1'b1, 1'b1);
        chk("R5 pll bit forced", rd_data[0], 1);
        chk("R5 other fields", rd_data[5:2], 4'hE);
        settle("R5 same edge");
        // R9: restart mid-wait
        wr(8'h32, 1'b1, 1'b0);
        repeat (10) @(negedge clk);
        chk("R9 mid wait", clk_src, 0);
        wr(8'h32, 1'b1, 1'b0); settle("R9 restart");
        wr(8'h00, 1'b0, 1'b1); settle("R5 wdog pll->main");
        // R6: sub priority with both bits clear
        wr(8'h00, 1'b1, 1'b0); settle("R6 sub priority");
        // R8: sub to PLL with short wait select
        wr(8'h06, 1'b1, 1'b0); settle("R8 clamp");
        wr(8'h01, 1'b1, 1'b0); settle("R6 pll->sub");
        // R7: sub to main
        wr(8'h23, 1'b1, 1'b0); settle("R7 sub->main");
        wr(8'h01, 1'b1, 1'b0); settle("R6 main->sub");
        wr(8'h3A, 1'b1, 1'b0); settle("R7 sub->pll");

        for (int i = 0; i < 60; i++) begin
            logic [7:0] d;
            logic wd;
            d  = 8'($urandom);
            wd = ($urandom % 6) == 0;
            wr(d, 1'b1, wd);
            settle("random");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule